// File: doc/BRIEF.md
# SPI Controller Host Register Front End

This block is the software-facing register bank of a command-driven SPI controller. A host issues single-cycle register writes and reads over a plain 32-bit port. Through it, software queues 16-bit instructions for the execution engine and queues transmit data words. It also collects received data words, reads how full each queue is, and takes interrupts. The engine side sees three show-ahead queues with valid/ready handshakes, one sync-completion strobe carrying an 8-bit identifier, and one hold output that keeps it idle.

The interrupt logic has four causes: three queue thresholds and engine sync completion. Each cause sets a pending bit. Software clears a pending bit by writing a one to it. A threshold bit sets itself again on every cycle that its condition still holds. The interrupt line is high while any pending bit is also enabled.

Top module: `spi_hostregs`

## Requirements
- R1: After reset, the control register at 0x40 reads 1, the enable register at 0x80 reads 0, the command room (0xD0) and transmit room (0xD4) read their depths, the receive level (0xD8) reads 0, `eng_hold` is 1 and `irq` is 0.
- R2: Writing 1 in bit 0 of 0x40 drives `eng_hold` high, empties all three queues and blocks every handshake. Writing 0 releases them.
- R3: A write to 0xE0 queues `wr_data[15:0]` as a command. Commands leave on `cmd_data` in arrival order. 0xD0 reads the number of free entries. A write to a full command queue is dropped.
- R4: A write to 0xE4 queues a transmit word. Transmit words leave on `sdo_data` in order. 0xD4 reads the free entries. A write to a full transmit queue is dropped.
- R5: The engine's receive words are accepted while the queue has room (`sdi_ready` is 0 when it is full). 0xD8 reads the number of stored words. A read of 0xE8 returns the oldest word and removes it. A read of 0xEC returns the oldest word and leaves it in place. A read of 0xE8 when the queue is empty returns 0 and changes nothing.
- R6: Pending bit 0 sets while the command count is at or below CMD_LOW. Bit 1 sets while the transmit count is at or below SDO_LOW. Bit 2 sets while the receive count is at or above SDI_HIGH. Each of these bits is set again on every cycle its condition holds.
- R7: Writing to 0x84 clears each pending bit whose data bit is 1. A bit whose cause still holds reads back set.
- R8: A `sync_valid` pulse stores `sync_id` in the register at 0xC0 and sets pending bit 3. Bit 3 stays set until it is cleared.
- R9: Bits [3:0] of 0x80 are the enables. 0x88 reads pending AND enable, and `irq` is high exactly when that value is nonzero.
- R10: Read data appears on `rd_data` in the cycle after `rd_en` and holds until the next read. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| eng_hold | output | 1 | Holds the engine idle |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Engine takes command |
| cmd_data | output | 16 | Oldest command |
| sdo_valid | output | 1 | Transmit word available |
| sdo_ready | input | 1 | Engine takes transmit word |
| sdo_data | output | DW | Oldest transmit word |
| sdi_valid | input | 1 | Engine offers received word |
| sdi_ready | output | 1 | Receive queue has room |
| sdi_data | input | DW | Received word |
| sync_valid | input | 1 | Sync instruction completed |
| sync_id | input | 8 | Identifier of that sync |
| irq | output | 1 | Level interrupt |

## Verification
A wrong queue count or pointer shows up at the ports as a wrong room or level value on the next read. It also shows up as a word out of order or a duplicated word on the first handshake that follows, which is within one or two cycles of the fault. A corrupted pending or enable bit shows in `irq` in the cycle after the edge that loads it, and it shows in the source register on the next read. The directed tests therefore read back the counts after every fill and drain. They follow each word through the queue and compare `irq` against the enables at each interrupt step.

// File: rtl/spi_hostregs.sv
module spi_hostregs #(
  parameter int CMD_DEPTH  = 16,
  parameter int DATA_DEPTH = 16,
  parameter int DW         = 32,
  parameter int CMD_LOW    = 4,
  parameter int SDO_LOW    = 4,
  parameter int SDI_HIGH   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    addr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic          eng_hold,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [15:0]   cmd_data,
  output logic          sdo_valid,
  input  logic          sdo_ready,
  output logic [DW-1:0] sdo_data,
  input  logic          sdi_valid,
  output logic          sdi_ready,
  input  logic [DW-1:0] sdi_data,
  input  logic          sync_valid,
  input  logic [7:0]    sync_id,
  output logic          irq
);
  localparam int CAW = $clog2(CMD_DEPTH);
  localparam int DAW = $clog2(DATA_DEPTH);
  localparam int CCW = CAW + 1;
  localparam int DCW = DAW + 1;

  localparam logic [7:0] A_HOLD = 8'h40, A_EN = 8'h80, A_PEND = 8'h84, A_SRC = 8'h88;
  localparam logic [7:0] A_SYNC = 8'hC0, A_CROOM = 8'hD0, A_DROOM = 8'hD4, A_ILVL = 8'hD8;
  localparam logic [7:0] A_CPUSH = 8'hE0, A_DPUSH = 8'hE4, A_IPOP = 8'hE8, A_IPEEK = 8'hEC;

  logic          hold_q;
  logic [3:0]    en_q, pend_q;
  logic [7:0]    sync_q;

  logic [15:0]   cmd_mem [CMD_DEPTH];
  logic [CAW-1:0] cmd_wp, cmd_rp;
  logic [CCW-1:0] cmd_cnt;

  logic [DW-1:0] sdo_mem [DATA_DEPTH];
  logic [DAW-1:0] sdo_wp, sdo_rp;
  logic [DCW-1:0] sdo_cnt;

  logic [DW-1:0] sdi_mem [DATA_DEPTH];
  logic [DAW-1:0] sdi_wp, sdi_rp;
  logic [DCW-1:0] sdi_cnt;

  wire cmd_full  = cmd_cnt == CCW'(CMD_DEPTH);
  wire sdo_full  = sdo_cnt == DCW'(DATA_DEPTH);
  wire sdi_full  = sdi_cnt == DCW'(DATA_DEPTH);

  wire cmd_push  = wr_en && addr == A_CPUSH && !hold_q && !cmd_full;
  wire sdo_push  = wr_en && addr == A_DPUSH && !hold_q && !sdo_full;
  wire cmd_pop   = cmd_valid && cmd_ready;
  wire sdo_pop   = sdo_valid && sdo_ready;
  wire sdi_push  = sdi_valid && sdi_ready;
  wire sdi_pop   = rd_en && addr == A_IPOP && sdi_cnt != '0;

  assign eng_hold  = hold_q;
  assign cmd_valid = !hold_q && cmd_cnt != '0;
  assign sdo_valid = !hold_q && sdo_cnt != '0;
  assign sdi_ready = !hold_q && !sdi_full;
  assign cmd_data  = cmd_mem[cmd_rp];
  assign sdo_data  = sdo_mem[sdo_rp];

  wire [DW-1:0] sdi_head = sdi_cnt != '0 ? sdi_mem[sdi_rp] : '0;
  wire [3:0]    cause = {sync_valid, sdi_cnt >= DCW'(SDI_HIGH),
                         sdo_cnt <= DCW'(SDO_LOW), cmd_cnt <= CCW'(CMD_LOW)};
  wire [3:0]    w1c   = (wr_en && addr == A_PEND) ? wr_data[3:0] : 4'h0;

  assign irq = |(pend_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      en_q   <= '0;
      pend_q <= '0;
      sync_q <= '0;
    end else begin
      if (wr_en && addr == A_HOLD) hold_q <= wr_data[0];
      if (wr_en && addr == A_EN)   en_q   <= wr_data[3:0];
      pend_q <= (pend_q & ~w1c) | cause;
      if (sync_valid) sync_q <= sync_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_wp <= '0; cmd_rp <= '0; cmd_cnt <= '0;
    end else if (hold_q) begin
      cmd_wp <= '0; cmd_rp <= '0; cmd_cnt <= '0;
    end else begin
      if (cmd_push) cmd_wp <= cmd_wp + 1'b1;
      if (cmd_pop)  cmd_rp <= cmd_rp + 1'b1;
      cmd_cnt <= cmd_cnt + CCW'(cmd_push) - CCW'(cmd_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_wp <= '0; sdo_rp <= '0; sdo_cnt <= '0;
    end else if (hold_q) begin
      sdo_wp <= '0; sdo_rp <= '0; sdo_cnt <= '0;
    end else begin
      if (sdo_push) sdo_wp <= sdo_wp + 1'b1;
      if (sdo_pop)  sdo_rp <= sdo_rp + 1'b1;
      sdo_cnt <= sdo_cnt + DCW'(sdo_push) - DCW'(sdo_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdi_wp <= '0; sdi_rp <= '0; sdi_cnt <= '0;
    end else if (hold_q) begin
      sdi_wp <= '0; sdi_rp <= '0; sdi_cnt <= '0;
    end else begin
      if (sdi_push) sdi_wp <= sdi_wp + 1'b1;
      if (sdi_pop)  sdi_rp <= sdi_rp + 1'b1;
      sdi_cnt <= sdi_cnt + DCW'(sdi_push) - DCW'(sdi_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (cmd_push) cmd_mem[cmd_wp] <= wr_data[15:0];
    if (sdo_push) sdo_mem[sdo_wp] <= wr_data[DW-1:0];
    if (sdi_push) sdi_mem[sdi_wp] <= sdi_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      case (addr)
        A_HOLD:  rd_data <= {31'd0, hold_q};
        A_EN:    rd_data <= {28'd0, en_q};
        A_PEND:  rd_data <= {28'd0, pend_q};
        A_SRC:   rd_data <= {28'd0, pend_q & en_q};
        A_SYNC:  rd_data <= {24'd0, sync_q};
        A_CROOM: rd_data <= 32'(CMD_DEPTH) - 32'(cmd_cnt);
        A_DROOM: rd_data <= 32'(DATA_DEPTH) - 32'(sdo_cnt);
        A_ILVL:  rd_data <= 32'(sdi_cnt);
        A_IPOP, A_IPEEK: rd_data <= 32'(sdi_head);
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

module spi_hostregs_chk #(
  parameter int CD  = 16,
  parameter int DD  = 16,
  parameter int CCW = 5,
  parameter int DCW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           eng_hold,
  input logic           cmd_valid,
  input logic           sdo_valid,
  input logic           sdi_ready,
  input logic [CCW-1:0] cmd_cnt,
  input logic [DCW-1:0] sdi_cnt,
  input logic           sync_valid,
  input logic [7:0]     sync_id,
  input logic [7:0]     sync_q,
  input logic [3:0]     pend_q,
  input logic [3:0]     en_q,
  input logic           irq,
  input logic           rd_en,
  input logic [31:0]    rd_data
);
  a_r2_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    eng_hold |-> (!cmd_valid && !sdo_valid && !sdi_ready));
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cnt <= CCW'(CD));
  a_r5_full_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (sdi_cnt == DCW'(DD)) |-> !sdi_ready);
  a_r8_id_latched: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> (sync_q == $past(sync_id)));
  a_r8_sync_pends: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> pend_q[3]);
  a_r9_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != 4'h0));
  a_r10_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind spi_hostregs spi_hostregs_chk #(.CD(CMD_DEPTH), .DD(DATA_DEPTH), .CCW(CCW), .DCW(DCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_hold(eng_hold), .cmd_valid(cmd_valid),
  .sdo_valid(sdo_valid), .sdi_ready(sdi_ready), .cmd_cnt(cmd_cnt), .sdi_cnt(sdi_cnt),
  .sync_valid(sync_valid), .sync_id(sync_id), .sync_q(sync_q), .pend_q(pend_q),
  .en_q(en_q), .irq(irq), .rd_en(rd_en), .rd_data(rd_data));

// File: tb/sim_spi_hostregs.sv
module sim_spi_hostregs;
  localparam int CD = 16, DD = 16, DW = 32;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic eng_hold, cmd_valid, cmd_ready = 0, sdo_valid, sdo_ready = 0;
  logic [15:0] cmd_data;
  logic [DW-1:0] sdo_data, sdi_data = 0;
  logic sdi_valid = 0, sdi_ready, sync_valid = 0, irq;
  logic [7:0] sync_id = 0;
  int total = 0, bad = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  spi_hostregs u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .eng_hold(eng_hold), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .sdo_valid(sdo_valid), .sdo_ready(sdo_ready),
    .sdo_data(sdo_data), .sdi_valid(sdi_valid), .sdi_ready(sdi_ready), .sdi_data(sdi_data),
    .sync_valid(sync_valid), .sync_id(sync_id), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic t_reset;
    bus_rd(8'h40, v); check("R1 hold reg", v, 1);
    bus_rd(8'h80, v); check("R1 enable", v, 0);
    bus_rd(8'hD0, v); check("R1 cmd room", v, CD);
    bus_rd(8'hD4, v); check("R1 sdo room", v, DD);
    bus_rd(8'hD8, v); check("R1 sdi level", v, 0);
    check("R1 hold/irq", {30'd0, eng_hold, irq}, 32'h2);
    bus_rd(8'h44, v); check("R10 unmapped", v, 0);
    bus_wr(8'h40, 0); check("R2 release", {31'd0, eng_hold}, 0);
  endtask

  task automatic t_cmd;
    for (int i = 0; i < CD + 2; i++) bus_wr(8'hE0, 32'hFFFF_A000 + i);
    bus_rd(8'hD0, v); check("R3 room full", v, 0);
    for (int i = 0; i < CD; i++) begin
      @(negedge clk);
      check("R3 cmd order", {15'd0, cmd_valid, cmd_data}, {15'd0, 1'b1, 16'hA000 + 16'(i)});
      cmd_ready = 1;
      @(negedge clk); cmd_ready = 0;
    end
    check("R3 dropped words", {31'd0, cmd_valid}, 0);
    bus_rd(8'hD0, v); check("R3 room empty", v, CD);
  endtask

  task automatic t_sdo;
    for (int i = 0; i < 3; i++) bus_wr(8'hE4, 32'h5000_0000 + i);
    bus_rd(8'hD4, v); check("R4 room", v, DD - 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R4 sdo order", sdo_data, 32'h5000_0000 + i);
      sdo_ready = 1;
      @(negedge clk); sdo_ready = 0;
    end
    check("R4 drained", {31'd0, sdo_valid}, 0);
    for (int i = 0; i < DD + 1; i++) bus_wr(8'hE4, i);
    bus_rd(8'hD4, v); check("R4 full room", v, 0);
    bus_wr(8'h40, 1);
    check("R2 hold blocks", {29'd0, eng_hold, sdo_valid, sdi_ready}, 32'h4);
    bus_rd(8'hD4, v); check("R2 flush", v, DD);
    bus_wr(8'h40, 0);
  endtask

  task automatic sdi_feed(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sdi_valid = 1; sdi_data = base + i;
    end
    @(negedge clk); sdi_valid = 0;
  endtask

  task automatic t_sdi;
    sdi_feed(3, 32'hC0DE_0000);
    bus_rd(8'hD8, v); check("R5 level", v, 3);
    bus_rd(8'hEC, v); check("R5 peek", v, 32'hC0DE_0000);
    bus_rd(8'hD8, v); check("R5 peek keeps", v, 3);
    for (int i = 0; i < 3; i++) begin
      bus_rd(8'hE8, v); check("R5 pop order", v, 32'hC0DE_0000 + i);
    end
    bus_rd(8'hE8, v); check("R5 empty pop", v, 0);
    bus_rd(8'hD8, v); check("R5 empty level", v, 0);
    sdi_feed(DD + 2, 32'h0);
    bus_rd(8'hD8, v); check("R5 full level", v, DD);
    check("R5 full ready", {31'd0, sdi_ready}, 0);
    bus_rd(8'hEC, v); check("R5 overflow kept oldest", v, 0);
    bus_wr(8'h40, 1); bus_wr(8'h40, 0);
  endtask

  task automatic t_irq;
    bus_wr(8'h84, 32'hFF);
    bus_rd(8'h84, v); check("R7 persistent causes", v, 32'h3);
    bus_rd(8'h88, v); check("R9 source none", v, 0);
    check("R9 irq off", {31'd0, irq}, 0);
    bus_wr(8'h80, 32'h4);
    check("R9 irq masked", {31'd0, irq}, 0);
    sdi_feed(12, 32'h100);
    bus_rd(8'h84, v); check("R6 almost full", v & 32'h4, 32'h4);
    bus_rd(8'h88, v); check("R9 source", v, 32'h4);
    check("R9 irq on", {31'd0, irq}, 1);
    for (int i = 0; i < 12; i++) bus_rd(8'hE8, v);
    check("R5 last popped", v, 32'h100 + 11);
    bus_wr(8'h84, 32'h4);
    bus_rd(8'h84, v); check("R7 cleared", v, 32'h3);
    check("R9 irq cleared", {31'd0, irq}, 0);
    for (int i = 0; i < 5; i++) bus_wr(8'hE0, i);
    bus_wr(8'h84, 32'h1);
    bus_rd(8'h84, v); check("R6 cmd above low", v & 32'h1, 0);
    @(negedge clk); sync_valid = 1; sync_id = 8'h5A;
    @(negedge clk); sync_valid = 0; sync_id = 8'h00;
    bus_rd(8'hC0, v); check("R8 id", v, 32'h5A);
    bus_rd(8'h84, v); check("R8 pending", v & 32'h8, 32'h8);
    bus_wr(8'h80, 32'h8);
    check("R9 sync irq", {31'd0, irq}, 1);
    bus_wr(8'h84, 32'h8);
    bus_rd(8'h84, v); check("R8 sync cleared", v & 32'h8, 0);
    check("R9 irq low", {31'd0, irq}, 0);
    bus_rd(8'hC0, v); check("R8 id kept", v, 32'h5A);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_cmd;
    t_sdo;
    t_sdi;
    t_irq;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule